// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block is the purely combinational control unit of a small non-pipelined load/store processor. It takes one 32-bit instruction word and, in the same cycle, produces everything the surrounding datapath needs. That covers the two register-file read addresses, the destination address and its write enable, the ALU operation and the source of the ALU's second operand. It also gives the data-memory read and write strobes, the write-back source and the next-PC source. The sign-extended immediate and the 26-bit absolute jump target are also presented so the datapath needs no field slicing of its own.

The supported set is register-register arithmetic and logic (add, subtract, multiply, divide, remainder, and, or, set-less-than), the same eight operations with an immediate operand, word load, word store, branch-if-equal, absolute jump and jump-through-register. Assembler shorthands (copy, increment, decrement, call) are expanded before the decoder sees them. The data memory is word-addressed, so offsets 0, 1, 2 select consecutive words. The branch target is PC + 1 + sign-extended offset. The PC logic outside the block computes it and takes it only when the compared registers are equal.

The instruction word is a control input, not a stream: it is decoded every cycle with no handshake, no storage and no back-pressure. A caller that stalls simply holds the word steady.

Top module: `instr_decoder`

## Requirements
- R1: Fields are taken as opcode = instr[31:26], rs_addr = instr[25:21], rt_addr = instr[20:16], rd = instr[15:11], funct = instr[5:0]. imm_ext is instr[15:0] sign-extended to 32 bits, and jump_target = instr[25:0], for every instruction word.
- R2: Opcode 0 with funct 0x20/0x22/0x18/0x1A/0x1B/0x24/0x25/0x2A selects alu_op 0 (add), 1 (sub), 2 (mul), 3 (div), 4 (mod), 5 (and), 6 (or) and 7 (slt) respectively. These decode with alu_b_imm=0, dst_addr=rd, reg_we=1, pc_sel=0, no memory access and wb_from_mem=0.
- R3: Opcodes 0x08/0x09/0x0A/0x0B/0x0C/0x0D/0x0E/0x0F select add/sub/slt/mul/and/or/div/mod (alu_op 0/1/7/2/5/6/3/4). These decode with alu_b_imm=1, dst_addr=rt, reg_we=1, pc_sel=0, no memory access.
- R4: Opcode 0x23 (load) gives alu_op=0, alu_b_imm=1, mem_rd=1, mem_wr=0, wb_from_mem=1, dst_addr=rt, reg_we=1, pc_sel=0.
- R5: Opcode 0x2B (store) gives alu_op=0, alu_b_imm=1, mem_wr=1, mem_rd=0, reg_we=0, dst_addr=0, pc_sel=0.
- R6: Opcode 0x04 (branch-if-equal) gives pc_sel=1, alu_op=1, alu_b_imm=0, reg_we=0, dst_addr=0, no memory access.
- R7: Opcode 0x02 (jump) gives pc_sel=2, reg_we=0, dst_addr=0, no memory access, alu_op=0, alu_b_imm=0.
- R8: Opcode 0 with funct 0x08 (jump-register) gives pc_sel=3, reg_we=0, dst_addr=0, no memory access, alu_op=0, alu_b_imm=0.
- R9: A writing instruction whose destination field is register 0 decodes with reg_we=0 and dst_addr=0; every other output keeps its value for that instruction.
- R10: Any opcode not listed above, and opcode 0 with a funct not listed, decodes as a no-operation. That means reg_we=0, mem_rd=0, mem_wr=0, wb_from_mem=0, pc_sel=0, alu_op=0, alu_b_imm=0, dst_addr=0.
- R11: mem_rd and mem_wr are never both 1, and wb_from_mem is 1 only when mem_rd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being decoded |
| rs_addr | output | 5 | First register read address |
| rt_addr | output | 5 | Second register read address |
| dst_addr | output | 5 | Register write address (0 when no write) |
| reg_we | output | 1 | Register file write enable |
| alu_op | output | 4 | ALU operation: 0 add, 1 sub, 2 mul, 3 div, 4 mod, 5 and, 6 or, 7 slt |
| alu_b_imm | output | 1 | ALU operand B: 0 register rt, 1 imm_ext |
| imm_ext | output | 32 | Sign-extended 16-bit immediate / offset |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| wb_from_mem | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| pc_sel | output | 2 | Next PC: 0 PC+1, 1 equal-branch candidate, 2 jump_target, 3 register rs |
| jump_target | output | 26 | Absolute jump address |

## Verification
The block holds no state, so a wrong internal classification shows at the ports in the same cycle the word is applied. It appears as a wrong operation code, a stray write or memory strobe, or a wrong next-PC choice, and nothing lingers into the following word. The bench therefore compares every output against an independent behavioural decode on every clock. It covers each listed encoding, each destination-zero case, unlisted opcodes and functs, and a long run of mixed random words. A misdecode of a single encoding would therefore surface on the first cycle that encoding is applied.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_MUL = 4'd2,
    ALU_DIV = 4'd3,
    ALU_MOD = 4'd4,
    ALU_AND = 4'd5,
    ALU_OR  = 4'd6,
    ALU_SLT = 4'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_JMP = 2'd2,
    NPC_REG = 2'd3
  } npc_e;

  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_RALU  = 3'd1,
    K_IALU  = 3'd2,
    K_LOAD  = 3'd3,
    K_STORE = 3'd4,
    K_BEQ   = 3'd5,
    K_JUMP  = 3'd6,
    K_JREG  = 3'd7
  } kind_e;

  // primary opcodes
  localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OP_SUBI  = 6'h09;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OP_MULI  = 6'h0B;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OP_DIVI  = 6'h0E;
  localparam logic [OPC_W-1:0] OP_MODI  = 6'h0F;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  // function codes under OP_REG
  localparam logic [FN_W-1:0] FN_JREG = 6'h08;
  localparam logic [FN_W-1:0] FN_MUL  = 6'h18;
  localparam logic [FN_W-1:0] FN_DIV  = 6'h1A;
  localparam logic [FN_W-1:0] FN_MOD  = 6'h1B;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RA_W  = 5,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  instr,
  output logic [OPC_W-1:0] opcode,
  output logic [FN_W-1:0]  funct,
  output logic [RA_W-1:0]  rs,
  output logic [RA_W-1:0]  rt,
  output logic [RA_W-1:0]  rd,
  output logic [XLEN-1:0]  imm_ext,
  output logic [JT_W-1:0]  jtarget
);
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS_LSB  = OPC_LSB - RA_W;
  localparam int RT_LSB  = RS_LSB - RA_W;
  localparam int RD_LSB  = RT_LSB - RA_W;
  localparam int EXT_W   = XLEN - IMM_W;

  assign opcode  = instr[XLEN-1:OPC_LSB];
  assign rs      = instr[RS_LSB +: RA_W];
  assign rt      = instr[RT_LSB +: RA_W];
  assign rd      = instr[RD_LSB +: RA_W];
  assign funct   = instr[FN_W-1:0];
  assign jtarget = instr[JT_W-1:0];

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    end else begin : g_noext
      assign imm_ext = instr[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output kind_e            kind,
  output alu_op_e          alu_op
);
  always_comb begin
    kind   = K_NOP;
    alu_op = ALU_ADD;
    unique case (opcode)
      OP_REG: begin
        kind = K_RALU;
        case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_MUL:  alu_op = ALU_MUL;
          FN_DIV:  alu_op = ALU_DIV;
          FN_MOD:  alu_op = ALU_MOD;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          FN_JREG: kind   = K_JREG;
          default: kind   = K_NOP;
        endcase
      end
      OP_ADDI:  begin kind = K_IALU; alu_op = ALU_ADD; end
      OP_SUBI:  begin kind = K_IALU; alu_op = ALU_SUB; end
      OP_SLTI:  begin kind = K_IALU; alu_op = ALU_SLT; end
      OP_MULI:  begin kind = K_IALU; alu_op = ALU_MUL; end
      OP_ANDI:  begin kind = K_IALU; alu_op = ALU_AND; end
      OP_ORI:   begin kind = K_IALU; alu_op = ALU_OR;  end
      OP_DIVI:  begin kind = K_IALU; alu_op = ALU_DIV; end
      OP_MODI:  begin kind = K_IALU; alu_op = ALU_MOD; end
      OP_LOAD:  kind = K_LOAD;
      OP_STORE: kind = K_STORE;
      OP_BEQ:   begin kind = K_BEQ; alu_op = ALU_SUB; end
      OP_JUMP:  kind = K_JUMP;
      default:  kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  kind_e           kind,
  input  logic [RA_W-1:0] rt,
  input  logic [RA_W-1:0] rd,
  output logic [RA_W-1:0] dst,
  output logic            reg_we,
  output logic            b_imm,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            wb_mem,
  output npc_e            npc
);
  logic [RA_W-1:0] dst_raw;
  logic            wants_write;

  always_comb begin
    dst_raw     = '0;
    wants_write = 1'b0;
    b_imm       = 1'b0;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    wb_mem      = 1'b0;
    npc         = NPC_SEQ;
    case (kind)
      K_RALU:  begin wants_write = 1'b1; dst_raw = rd; end
      K_IALU:  begin wants_write = 1'b1; dst_raw = rt; b_imm = 1'b1; end
      K_LOAD:  begin wants_write = 1'b1; dst_raw = rt; b_imm = 1'b1;
                     mem_rd = 1'b1; wb_mem = 1'b1; end
      K_STORE: begin b_imm = 1'b1; mem_wr = 1'b1; end
      K_BEQ:   npc = NPC_BR;
      K_JUMP:  npc = NPC_JMP;
      K_JREG:  npc = NPC_REG;
      default: ;
    endcase
  end

  // register 0 is hard-wired: drop the write entirely
  assign reg_we = wants_write && (dst_raw != '0);
  assign dst    = reg_we ? dst_raw : '0;

  always_comb begin
    p_we_nonzero_r9: assert (!reg_we || dst != '0)
      else $error("write to register 0 not suppressed");
    p_mem_excl_r11: assert (!(mem_rd && mem_wr))
      else $error("simultaneous memory read and write");
    p_wb_needs_rd_r11: assert (!wb_mem || mem_rd)
      else $error("memory write-back without memory read");
    p_ctl_flow_nowrite_r6: assert (npc == NPC_SEQ || (!reg_we && !mem_rd && !mem_wr))
      else $error("control transfer with side effect");
    p_store_nowrite_r5: assert (!mem_wr || !reg_we)
      else $error("store also writes a register");
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RA_W  = 5,
  parameter int IMM_W = 16,
  parameter int JT_W  = XLEN - OPC_W
) (
  input  logic [XLEN-1:0] instr,
  output logic [RA_W-1:0] rs_addr,
  output logic [RA_W-1:0] rt_addr,
  output logic [RA_W-1:0] dst_addr,
  output logic            reg_we,
  output logic [3:0]      alu_op,
  output logic            alu_b_imm,
  output logic [XLEN-1:0] imm_ext,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            wb_from_mem,
  output logic [1:0]      pc_sel,
  output logic [JT_W-1:0] jump_target
);
  logic [OPC_W-1:0] opcode;
  logic [FN_W-1:0]  funct;
  logic [RA_W-1:0]  rd_f;
  kind_e            kind;
  alu_op_e          alu_sel;
  npc_e             npc;

  idec_fields #(.XLEN(XLEN), .RA_W(RA_W), .IMM_W(IMM_W), .JT_W(JT_W)) u_fields (
    .instr   (instr),
    .opcode  (opcode),
    .funct   (funct),
    .rs      (rs_addr),
    .rt      (rt_addr),
    .rd      (rd_f),
    .imm_ext (imm_ext),
    .jtarget (jump_target)
  );

  idec_classify u_class (
    .opcode (opcode),
    .funct  (funct),
    .kind   (kind),
    .alu_op (alu_sel)
  );

  idec_ctrl #(.RA_W(RA_W)) u_ctrl (
    .kind   (kind),
    .rt     (rt_addr),
    .rd     (rd_f),
    .dst    (dst_addr),
    .reg_we (reg_we),
    .b_imm  (alu_b_imm),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .wb_mem (wb_from_mem),
    .npc    (npc)
  );

  assign alu_op = alu_sel;
  assign pc_sel = npc;

  always_comb begin
    // a write must target one of the instruction's own register fields
    p_dst_is_field_r2: assert (!reg_we || dst_addr == rd_f || dst_addr == rt_addr)
      else $error("destination not taken from rd or rt");
    // immediate operand only for non-register-register, non-branch kinds
    p_bimm_kind_r3: assert (!alu_b_imm || (pc_sel == 2'd0 && !(opcode == OP_REG)))
      else $error("immediate operand selected for wrong format");
  end
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr = '0;
  logic [4:0]  rs_addr, rt_addr, dst_addr;
  logic        reg_we, alu_b_imm, mem_rd, mem_wr, wb_from_mem;
  logic [3:0]  alu_op;
  logic [31:0] imm_ext;
  logic [1:0]  pc_sel;
  logic [25:0] jump_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  instr_decoder dut_i (
    .instr(instr), .rs_addr(rs_addr), .rt_addr(rt_addr), .dst_addr(dst_addr),
    .reg_we(reg_we), .alu_op(alu_op), .alu_b_imm(alu_b_imm), .imm_ext(imm_ext),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .pc_sel(pc_sel), .jump_target(jump_target)
  );

  // behavioural reference: returns packed control {dst,we,alu,bimm,mrd,mwr,wbm,pc}
  function automatic logic [15:0] ref_ctl(input logic [31:0] w, output string tag);
    int op, fn, rt, rd, alu, dst, pc;
    bit we, bimm, mrd, mwr, wbm, write;
    op = int'(w[31:26]); fn = int'(w[5:0]);
    rt = int'(w[20:16]); rd = int'(w[15:11]);
    alu = 0; dst = 0; pc = 0; we = 0; bimm = 0; mrd = 0; mwr = 0; wbm = 0; write = 0;
    tag = "R10";
    if (op == 0) begin
      write = 1; dst = rd; tag = "R2";
      case (fn)
        'h20: alu = 0;  'h22: alu = 1;  'h18: alu = 2;  'h1A: alu = 3;
        'h1B: alu = 4;  'h24: alu = 5;  'h25: alu = 6;  'h2A: alu = 7;
        'h08: begin write = 0; dst = 0; pc = 3; tag = "R8"; end
        default: begin write = 0; dst = 0; tag = "R10"; end
      endcase
    end else if (op >= 'h08 && op <= 'h0F) begin
      int imap[8] = '{0, 1, 7, 2, 5, 6, 3, 4};
      write = 1; dst = rt; bimm = 1; alu = imap[op - 8]; tag = "R3";
    end else if (op == 'h23) begin
      write = 1; dst = rt; bimm = 1; mrd = 1; wbm = 1; tag = "R4";
    end else if (op == 'h2B) begin
      bimm = 1; mwr = 1; tag = "R5";
    end else if (op == 'h04) begin
      alu = 1; pc = 1; tag = "R6";
    end else if (op == 'h02) begin
      pc = 2; tag = "R7";
    end
    if (write && dst == 0) begin
      tag = "R9";
    end
    we = write && (dst != 0);
    if (!we) dst = 0;
    return {dst[4:0], we, alu[3:0], bimm, mrd, mwr, wbm, pc[1:0]};
  endfunction

  task automatic check_now();
    string tag;
    logic [15:0] exp_c, got_c;
    logic [67:0] exp_f, got_f;
    exp_c = ref_ctl(instr, tag);
    got_c = {dst_addr, reg_we, alu_op, alu_b_imm, mem_rd, mem_wr, wb_from_mem, pc_sel};
    checks++;
    if (got_c !== exp_c) begin
      errors++;
      $display("FAIL %s instr=%h ctl actual=%h expected=%h", tag, instr, got_c, exp_c);
    end
    // R1 field extraction
    exp_f = {instr[25:21], instr[20:16], {{16{instr[15]}}, instr[15:0]}, instr[25:0]};
    got_f = {rs_addr, rt_addr, imm_ext, jump_target};
    checks++;
    if (got_f !== exp_f) begin
      errors++;
      $display("FAIL R1 instr=%h fields actual=%h expected=%h", instr, got_f, exp_f);
    end
    // R11 strobe exclusivity
    checks++;
    if ((mem_rd && mem_wr) || (wb_from_mem && !mem_rd)) begin
      errors++;
      $display("FAIL R11 instr=%h actual rd=%0b wr=%0b wb=%0b expected exclusive",
               instr, mem_rd, mem_wr, wb_from_mem);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
    check_now();
  endtask

  function automatic logic [31:0] enc(input int op, input int rs, input int rt,
                                      input int rd, input int low);
    return {op[5:0], rs[4:0], rt[4:0], rd[4:0], low[10:0]};
  endfunction

  initial begin
    int fns[9] = '{'h20, 'h22, 'h18, 'h1A, 'h1B, 'h24, 'h25, 'h2A, 'h08};
    int ops[16] = '{0, 0, 'h02, 'h04, 'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E,
                    'h0F, 'h23, 'h2B, 'h3F, 'h11};
    // reset phase: all-zero word must decode to no-operation (R10)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now();
    rst_n = 1'b1;
    // R2 every register-register op; R8 jump-register
    foreach (fns[i]) apply(enc(0, 3, 4, 5, fns[i]));
    // R3 every immediate op, negative immediate for sign extension (R1)
    for (int op = 8; op < 16; op++) apply({op[5:0], 5'd2, 5'd6, 16'hFFF0});
    apply({6'h23, 5'd1, 5'd7, 16'h0002});   // R4 load
    apply({6'h2B, 5'd1, 5'd7, 16'h0001});   // R5 store
    apply({6'h04, 5'd8, 5'd9, 16'h8000});   // R6 branch, most negative offset
    apply({6'h02, 26'h3FFFFFF});            // R7 jump, full target
    apply(enc(0, 3, 4, 0, 'h20));           // R9 rd = 0
    apply({6'h08, 5'd2, 5'd0, 16'h0005});   // R9 rt = 0 immediate
    apply({6'h23, 5'd2, 5'd0, 16'h0000});   // R9 load to register 0
    apply(enc(0, 3, 4, 5, 'h21));           // R10 unlisted funct
    apply({6'h3F, 26'h1234567});            // R10 unlisted opcode
    apply({6'h05, 26'h0ABCDEF});            // R10 unlisted opcode
    // mixed random words
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:26] = 6'(ops[$urandom_range(15, 0)]);
      if (w[31:26] == 0) w[5:0] = 6'(fns[$urandom_range(8, 0)]);
      if ($urandom_range(7, 0) == 0) w[20:11] = '0;
      apply(w);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule